// File: doc/BRIEF.md
# Processor exception recognition and entry

This block sits beside the instruction sequencer. Each cycle it looks at the pending exception conditions and the enable bits held in the machine-state register (MSR). It decides which condition, if any, may be taken. In the cycle a condition is accepted, the block saves the architectural state: a return address goes into save/restore register 0 (SRR0), and a mix of cause bits and copied MSR bits goes into save/restore register 1 (SRR1). The MSR is updated so that asynchronous requests are held off until software allows them again.

Each class of condition is masked in its own way:

- System reset cannot be masked.
- A machine check is qualified per source by hardware enable bits. The MSR machine-check enable then chooses between a trap and a permanent checkstop.
- IEEE floating-point traps are gated by a two-bit floating-point mode field.
- External and decrementer requests wait for the external-enable bit.

Instruction-caused and asynchronous exceptions are also held back until every older instruction-caused exception has retired.

The MSR lives inside the block. Software-style writes of the MSR arrive on a plain load strobe. The sequencer watches a one-cycle taken strobe and a 3-bit cause code, then reads SRR0 and SRR1. All control pins are plain levels and strobes. The block has no streaming data path, so it has no back-pressure.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `exc_taken` and `checkstop` are 0, SRR0 and SRR1 are 0, and the MSR equals the parameter `RST_MSR`.
- R2: A system reset request is taken with cause 1 whatever the MSR enables hold. When another exception is taken, no system reset was requested at the deciding edge.
- R3: A machine-check source counts only when its bit in `mc_en` is 1. A source whose enable is 0 causes neither a trap nor a checkstop.
- R4: When a machine-check condition is present and ME (MSR big-endian bit 19, vector index 12) is 1, it is taken with cause 2. When ME is 0, `checkstop` rises one cycle later, nothing is taken in that cycle, and from then on nothing is taken and `checkstop` stays 1 until `rst_n`.
- R5: A floating-point trap request is ignored while FE0 and FE1 (big-endian bits 20 and 23, vector indices 11 and 8) are both 0. With either bit set it is taken with cause 3, and every nonzero setting behaves the same.
- R6: Causes 3 to 6 are taken only while `older_clear` is 1. System reset and machine check do not wait for it.
- R7: The external request is a level. It is taken with cause 5 only while EE (big-endian bit 16, vector index 15) is 1, and it stays pending while EE is 0.
- R8: A one-cycle `dec_evt` pulse is latched as pending. The pending decrementer is taken with cause 6 once EE is 1 and `older_clear` is 1, and is cleared when it is taken.
- R9: Priority, from highest to lowest, is cause 1, 2, 3, 4, 5, 6. At most one exception is taken per decision, and nothing is taken at the edge that follows a take.
- R10: On a take, SRR0 is loaded with `fault_pc` for causes 3 and 4, and with `next_pc` for all other causes. SRR0 holds its value otherwise.
- R11: On a take, SRR1 is loaded as follows (bit 0 is the MSB):
  - Bits 5–9 and 16–31 copy the MSR.
  - Bits 1–4 take cause-field bits 9..6, and bits 10–15 take cause-field bits 5..0.
  - Bit 0 is 0.
  - The cause field is `prog_info` for cause 4, 10'h010 for cause 3 (SRR1 bit 11 set), and 0 for every other cause.
- R12: A take clears EE and leaves every other MSR bit as it was. When there is no take, `msr_wr_en` loads `msr_wr_val`.
- R13: `exc_taken` is a one-cycle pulse one clock after the deciding edge. Whenever it is 1, `exc_cause` holds a code from 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msr_wr_en | input | 1 | Load the MSR from `msr_wr_val` |
| msr_wr_val | input | 32 | New MSR value |
| mc_en | input | MC_SRCS | Per-source machine-check enables |
| sreset_req | input | 1 | System reset request |
| mc_src | input | MC_SRCS | Machine-check source conditions |
| fp_req | input | 1 | IEEE floating-point enabled trap condition |
| prog_req | input | 1 | Other program exception condition |
| prog_info | input | 10 | Cause field for program exceptions |
| ext_req | input | 1 | External interrupt level |
| dec_evt | input | 1 | Decrementer event pulse |
| older_clear | input | 1 | All older instruction-caused exceptions have retired |
| fault_pc | input | PC_W | Address of the faulting instruction |
| next_pc | input | PC_W | Address of the next unexecuted instruction |
| exc_taken | output | 1 | Exception taken strobe |
| exc_cause | output | 3 | Cause code of the taken exception |
| srr0 | output | PC_W | Saved return address |
| srr1 | output | 32 | Saved cause and state bits |
| msr_out | output | 32 | Current MSR |
| checkstop | output | 1 | Checkstop state |

## Verification
The bench builds the block with `PC_W` = 30 and `MC_SRCS` = 5. The odd widths show that the SRR0 path and the machine-check source reduction do not depend on the default 32/4 values. `RST_MSR` stays 0, so ME is clear after reset and the checkstop path is reachable without any setup. Five sources with per-episode random enables let disabled sources fire alongside enabled ones, and random MSR loads sweep every FE combination and both values of EE and ME.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int MSR_W  = 32;
  localparam int INFO_W = 10;

  // MSR fields, big-endian bit k sits at vector index 31-k
  localparam int EE_IDX  = MSR_W - 1 - 16;
  localparam int ME_IDX  = MSR_W - 1 - 19;
  localparam int FE0_IDX = MSR_W - 1 - 20;
  localparam int FE1_IDX = MSR_W - 1 - 23;

  // sources in priority order, index i reports cause i+1
  localparam int SRC_SRST = 0;
  localparam int SRC_MCHK = 1;
  localparam int SRC_FPX  = 2;
  localparam int SRC_PROG = 3;
  localparam int SRC_EXT  = 4;
  localparam int SRC_DEC  = 5;
  localparam int NSRC     = 6;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_SRST = 3'd1,
    CAUSE_MCHK = 3'd2,
    CAUSE_FPX  = 3'd3,
    CAUSE_PROG = 3'd4,
    CAUSE_EXT  = 3'd5,
    CAUSE_DEC  = 3'd6
  } cause_e;

  // big-endian bits 5..9 and 16..31 are copied from the MSR
  localparam logic [MSR_W-1:0] SRR1_COPY_MASK = 32'h07C0_FFFF;
  localparam logic [INFO_W-1:0] FPX_INFO      = 10'h010;

  function automatic logic [MSR_W-1:0] srr1_pack(input logic [INFO_W-1:0] info,
                                                 input logic [MSR_W-1:0]  msr);
    logic [MSR_W-1:0] r;
    r          = msr & SRR1_COPY_MASK;
    r[30:27]   = info[9:6];
    r[21:16]   = info[5:0];
    return r;
  endfunction

endpackage

// File: rtl/exc_qualify.sv
module exc_qualify
  import exc_pkg::*;
#(
  parameter int MC_SRCS = 4
) (
  input  logic               ee,
  input  logic               me,
  input  logic               fe0,
  input  logic               fe1,
  input  logic               checkstop_q,
  input  logic               busy_q,
  input  logic               dec_pend_q,
  input  logic               sreset_req,
  input  logic [MC_SRCS-1:0] mc_src,
  input  logic [MC_SRCS-1:0] mc_en,
  input  logic               fp_req,
  input  logic               prog_req,
  input  logic               ext_req,
  input  logic               older_clear,
  output logic [NSRC-1:0]    elig,
  output logic               cstop_hit
);

  logic mc_cond;
  logic fp_mode_on;
  logic allow;
  logic async_ok;

  assign mc_cond    = |(mc_src & mc_en);
  assign fp_mode_on = fe0 | fe1;
  assign cstop_hit  = !checkstop_q && mc_cond && !me;
  assign allow      = !checkstop_q && !busy_q && !cstop_hit;
  assign async_ok   = ee && older_clear;

  always_comb begin
    elig           = '0;
    elig[SRC_SRST] = allow && sreset_req;
    elig[SRC_MCHK] = allow && mc_cond;
    elig[SRC_FPX]  = allow && fp_req && fp_mode_on && older_clear;
    elig[SRC_PROG] = allow && prog_req && older_clear;
    elig[SRC_EXT]  = allow && ext_req && async_ok;
    elig[SRC_DEC]  = allow && dec_pend_q && async_ok;
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] && !seen[i];
    assign seen[i+1] = seen[i] || req[i];
  end

  assign any = seen[N];

endmodule

// File: rtl/exc_save.sv
module exc_save
  import exc_pkg::*;
#(
  parameter int               PC_W    = 32,
  parameter logic [MSR_W-1:0] RST_MSR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   grant,
  input  logic              take,
  input  logic              cstop_hit,
  input  logic              msr_wr_en,
  input  logic [MSR_W-1:0]  msr_wr_val,
  input  logic [PC_W-1:0]   fault_pc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [INFO_W-1:0] prog_info,
  input  logic              dec_evt,
  output logic              taken_q,
  output cause_e            cause_q,
  output logic [PC_W-1:0]   srr0_q,
  output logic [MSR_W-1:0]  srr1_q,
  output logic [MSR_W-1:0]  msr_q,
  output logic              checkstop_q,
  output logic              dec_pend_q
);

  cause_e            cause_d;
  logic [INFO_W-1:0] info_d;
  logic [PC_W-1:0]   srr0_d;
  logic [MSR_W-1:0]  msr_entry;

  always_comb begin
    cause_d = CAUSE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (grant[i]) cause_d = cause_e'(3'(i + 1));
    end
  end

  always_comb begin
    if (grant[SRC_PROG])     info_d = prog_info;
    else if (grant[SRC_FPX]) info_d = FPX_INFO;
    else                     info_d = '0;
  end

  assign srr0_d = (grant[SRC_FPX] || grant[SRC_PROG]) ? fault_pc : next_pc;

  always_comb begin
    msr_entry         = msr_q;
    msr_entry[EE_IDX] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q     <= 1'b0;
      cause_q     <= CAUSE_NONE;
      srr0_q      <= '0;
      srr1_q      <= '0;
      msr_q       <= RST_MSR;
      checkstop_q <= 1'b0;
      dec_pend_q  <= 1'b0;
    end else begin
      taken_q     <= take;
      checkstop_q <= checkstop_q || cstop_hit;
      dec_pend_q  <= (dec_pend_q && !grant[SRC_DEC]) || dec_evt;
      if (take) begin
        cause_q <= cause_d;
        srr0_q  <= srr0_d;
        srr1_q  <= srr1_pack(info_d, msr_q);
        msr_q   <= msr_entry;
      end else if (msr_wr_en) begin
        msr_q   <= msr_wr_val;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          PC_W    = 32,
  parameter int          MC_SRCS = 4,
  parameter logic [31:0] RST_MSR = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msr_wr_en,
  input  logic [31:0]        msr_wr_val,
  input  logic [MC_SRCS-1:0] mc_en,
  input  logic               sreset_req,
  input  logic [MC_SRCS-1:0] mc_src,
  input  logic               fp_req,
  input  logic               prog_req,
  input  logic [9:0]         prog_info,
  input  logic               ext_req,
  input  logic               dec_evt,
  input  logic               older_clear,
  input  logic [PC_W-1:0]    fault_pc,
  input  logic [PC_W-1:0]    next_pc,
  output logic               exc_taken,
  output logic [2:0]         exc_cause,
  output logic [PC_W-1:0]    srr0,
  output logic [31:0]        srr1,
  output logic [31:0]        msr_out,
  output logic               checkstop
);

  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  grant;
  logic             take;
  logic             cstop_hit;
  logic             taken_q;
  cause_e           cause_q;
  logic [MSR_W-1:0] msr_q;
  logic             checkstop_q;
  logic             dec_pend_q;

  exc_qualify #(.MC_SRCS(MC_SRCS)) u_qual (
    .ee          (msr_q[EE_IDX]),
    .me          (msr_q[ME_IDX]),
    .fe0         (msr_q[FE0_IDX]),
    .fe1         (msr_q[FE1_IDX]),
    .checkstop_q (checkstop_q),
    .busy_q      (taken_q),
    .dec_pend_q  (dec_pend_q),
    .sreset_req  (sreset_req),
    .mc_src      (mc_src),
    .mc_en       (mc_en),
    .fp_req      (fp_req),
    .prog_req    (prog_req),
    .ext_req     (ext_req),
    .older_clear (older_clear),
    .elig        (elig),
    .cstop_hit   (cstop_hit)
  );

  exc_arbiter #(.N(NSRC)) u_arb (
    .req   (elig),
    .grant (grant),
    .any   (take)
  );

  exc_save #(.PC_W(PC_W), .RST_MSR(RST_MSR)) u_save (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant       (grant),
    .take        (take),
    .cstop_hit   (cstop_hit),
    .msr_wr_en   (msr_wr_en),
    .msr_wr_val  (msr_wr_val),
    .fault_pc    (fault_pc),
    .next_pc     (next_pc),
    .prog_info   (prog_info),
    .dec_evt     (dec_evt),
    .taken_q     (taken_q),
    .cause_q     (cause_q),
    .srr0_q      (srr0),
    .srr1_q      (srr1),
    .msr_q       (msr_q),
    .checkstop_q (checkstop_q),
    .dec_pend_q  (dec_pend_q)
  );

  assign exc_taken = taken_q;
  assign exc_cause = cause_q;
  assign msr_out   = msr_q;
  assign checkstop = checkstop_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_taken,
  input logic [2:0]      exc_cause,
  input logic [31:0]     msr_out,
  input logic            checkstop,
  input logic            sreset_req,
  input logic            older_clear,
  input logic [PC_W-1:0] fault_pc,
  input logic [PC_W-1:0] srr0
);

  p_taken_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> !exc_taken);

  p_cause_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (exc_cause != 3'd0 && exc_cause <= 3'd6));

  p_ee_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> !msr_out[EE_IDX]);

  p_cstop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop);

  p_cstop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |-> !exc_taken);

  p_sreset_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_cause != 3'd1) |-> !$past(sreset_req));

  p_older_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_cause >= 3'd3) |-> $past(older_clear));

  p_fp_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_cause == 3'd3) |-> ($past(msr_out[FE0_IDX]) || $past(msr_out[FE1_IDX])));

  p_async_ee_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_cause >= 3'd5) |-> $past(msr_out[EE_IDX]));

  p_srr0_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && (exc_cause == 3'd3 || exc_cause == 3'd4)) |-> (srr0 == $past(fault_pc)));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .exc_taken   (exc_taken),
  .exc_cause   (exc_cause),
  .msr_out     (msr_out),
  .checkstop   (checkstop),
  .sreset_req  (sreset_req),
  .older_clear (older_clear),
  .fault_pc    (fault_pc),
  .srr0        (srr0)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

  localparam int PW  = 30;
  localparam int MCS = 5;
  localparam logic [31:0] M_EE  = 32'h0000_8000;
  localparam logic [31:0] M_ME  = 32'h0000_1000;
  localparam logic [31:0] M_FE0 = 32'h0000_0800;
  localparam logic [31:0] M_FE1 = 32'h0000_0100;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           msr_wr_en;
  logic [31:0]    msr_wr_val;
  logic [MCS-1:0] mc_en;
  logic           sreset_req;
  logic [MCS-1:0] mc_src;
  logic           fp_req, prog_req, ext_req, dec_evt, older_clear;
  logic [9:0]     prog_info;
  logic [PW-1:0]  fault_pc, next_pc;
  logic           exc_taken;
  logic [2:0]     exc_cause;
  logic [PW-1:0]  srr0;
  logic [31:0]    srr1, msr_out;
  logic           checkstop;

  exc_entry_ctrl #(.PC_W(PW), .MC_SRCS(MCS), .RST_MSR(32'h0)) u_dut (
    .clk(clk), .rst_n(rst_n), .msr_wr_en(msr_wr_en), .msr_wr_val(msr_wr_val),
    .mc_en(mc_en), .sreset_req(sreset_req), .mc_src(mc_src), .fp_req(fp_req),
    .prog_req(prog_req), .prog_info(prog_info), .ext_req(ext_req), .dec_evt(dec_evt),
    .older_clear(older_clear), .fault_pc(fault_pc), .next_pc(next_pc),
    .exc_taken(exc_taken), .exc_cause(exc_cause), .srr0(srr0), .srr1(srr1),
    .msr_out(msr_out), .checkstop(checkstop)
  );

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  logic [31:0]   m_msr, m_srr1;
  logic [PW-1:0] m_srr0;
  logic [2:0]    m_cause;
  logic          m_taken, m_ck, m_dpend;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] build_srr1(input logic [9:0] info, input logic [31:0] msr);
    logic [31:0] r = '0;
    for (int k = 0; k < 32; k++) begin
      if ((k >= 5 && k <= 9) || k >= 16) r[31-k] = msr[31-k];
      else if (k >= 1 && k <= 4)         r[31-k] = info[9-(k-1)];
      else if (k >= 10 && k <= 15)       r[31-k] = info[5-(k-10)];
    end
    return r;
  endfunction

  task automatic idle();
    msr_wr_en = 0; msr_wr_val = '0; sreset_req = 0; mc_src = '0;
    fp_req = 0; prog_req = 0; prog_info = '0; ext_req = 0; dec_evt = 0;
    older_clear = 1; fault_pc = PW'(32'h0AB0_1000); next_pc = PW'(32'h0AB0_1004);
  endtask

  task automatic model_reset();
    m_msr = 32'h0; m_srr1 = '0; m_srr0 = '0; m_cause = '0;
    m_taken = 0; m_ck = 0; m_dpend = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle();
    repeat (2) @(negedge clk);
    model_reset();
    chk(exc_taken == 0 && checkstop == 0, "R1 strobe/checkstop", {exc_taken, checkstop}, 0);
    chk(srr0 == 0 && srr1 == 0, "R1 srr", srr1, 0);
    chk(msr_out == 32'h0, "R1 msr", msr_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(exc_taken == 0 && checkstop == 0 && msr_out == 0, "R1 after release", msr_out, 0);
  endtask

  // one decision edge: compute expectation, clock, compare
  task automatic step();
    logic          mc, ee, me, fe;
    logic [2:0]    code;
    logic [31:0]   n_msr, n_srr1;
    logic [PW-1:0] n_srr0;
    logic [2:0]    n_cause;
    logic          n_ck, n_dp;
    logic [9:0]    info;
    mc = |(mc_src & mc_en);
    ee = m_msr[15]; me = m_msr[12]; fe = m_msr[11] | m_msr[8];
    code = 0;
    n_ck = m_ck; n_msr = m_msr; n_srr0 = m_srr0; n_srr1 = m_srr1; n_cause = m_cause;
    n_dp = m_dpend | dec_evt;
    if (!m_ck) begin
      if (mc && !me) n_ck = 1;
      else if (!m_taken) begin
        if (sreset_req)                             code = 1;
        else if (mc)                                code = 2;
        else if (older_clear && fp_req && fe)       code = 3;
        else if (older_clear && prog_req)           code = 4;
        else if (older_clear && ext_req && ee)      code = 5;
        else if (older_clear && m_dpend && ee)      code = 6;
      end
    end
    if (code != 0) begin
      info = (code == 4) ? prog_info : (code == 3) ? 10'h010 : 10'h000;
      n_cause = code;
      n_srr0  = (code == 3 || code == 4) ? fault_pc : next_pc;
      n_srr1  = build_srr1(info, m_msr);
      n_msr   = m_msr & ~M_EE;
      if (code == 6) n_dp = dec_evt;
    end else if (msr_wr_en) begin
      n_msr = msr_wr_val;
    end
    @(posedge clk);
    @(negedge clk);
    chk(exc_taken == (code != 0), "R13 taken strobe", exc_taken, code != 0);
    if (code != 0) chk(exc_cause == code, "R9 cause/priority", exc_cause, code);
    chk(srr0 == n_srr0, "R10 srr0", srr0, n_srr0);
    chk(srr1 == n_srr1, "R11 srr1", srr1, n_srr1);
    chk(msr_out == n_msr, "R12 msr", msr_out, n_msr);
    chk(checkstop == n_ck, "R4 checkstop", checkstop, n_ck);
    m_taken = (code != 0); m_msr = n_msr; m_srr0 = n_srr0; m_srr1 = n_srr1;
    m_cause = n_cause; m_ck = n_ck; m_dpend = n_dp;
  endtask

  task automatic expect_take(input logic [2:0] code, input string req);
    if (code == 0) chk(exc_taken == 0, req, exc_taken, 0);
    else chk(exc_taken == 1 && exc_cause == code, req, exc_cause, code);
  endtask

  task automatic wr_msr(input logic [31:0] v);
    msr_wr_en = 1; msr_wr_val = v; step(); msr_wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mc_en = '0;
    idle();
    do_reset();

    // R2: unmaskable system reset with every enable clear
    sreset_req = 1; step(); expect_take(1, "R2 sreset unmasked");
    sreset_req = 0; step();

    // R5: fp trap ignored with FE=00, taken with FE1 set
    wr_msr(M_ME);
    fp_req = 1; step(); expect_take(0, "R5 fp ignored FE=00");
    step(); expect_take(0, "R5 fp ignored FE=00");
    wr_msr(M_ME | M_FE1);
    step(); expect_take(3, "R5 fp taken FE=01");
    chk(srr0 == fault_pc, "R10 fp srr0", srr0, fault_pc);
    chk(srr1[20] == 1'b1, "R11 fp cause bit", srr1, 32'h0010_0000);
    fp_req = 0; step();

    // R7: external held while EE=0
    ext_req = 1;
    repeat (3) begin step(); expect_take(0, "R7 ext held EE=0"); end
    wr_msr(M_ME | M_EE);
    step(); expect_take(5, "R7 ext taken EE=1");
    chk(srr0 == next_pc, "R10 async srr0", srr0, next_pc);
    chk(msr_out[15] == 0, "R12 EE cleared", msr_out, M_ME);
    ext_req = 0; step();

    // R8: decrementer pulse latched
    dec_evt = 1; step(); expect_take(0, "R8 dec deferred");
    dec_evt = 0; step(); step(); expect_take(0, "R8 dec deferred");
    wr_msr(M_ME | M_EE);
    step(); expect_take(6, "R8 dec taken from pending");
    step(); step(); expect_take(0, "R8 pending cleared");

    // R6: program exception waits for older_clear
    prog_req = 1; prog_info = 10'h2A5; older_clear = 0;
    step(); step(); expect_take(0, "R6 prog waits");
    older_clear = 1; step(); expect_take(4, "R6 prog taken");
    chk(srr1 == build_srr1(10'h2A5, M_ME), "R11 prog info", srr1, build_srr1(10'h2A5, M_ME));
    prog_req = 0; step();

    // R3: disabled source, ME=0 yet no checkstop
    wr_msr(32'h0);
    mc_en = 5'b00010; mc_src = 5'b00001;
    step(); step(); expect_take(0, "R3 disabled source");
    chk(checkstop == 0, "R3 no checkstop", checkstop, 0);
    mc_src = '0;

    // R9: everything at once
    wr_msr(M_ME | M_EE | M_FE0 | M_FE1);
    sreset_req = 1; mc_src = 5'b00010; fp_req = 1; prog_req = 1; ext_req = 1; dec_evt = 1;
    step(); expect_take(1, "R9 sreset first"); dec_evt = 0;
    step(); expect_take(0, "R9 gap after take");
    sreset_req = 0; step(); expect_take(2, "R4 mc trap ME=1");
    step(); mc_src = '0;
    step(); expect_take(3, "R9 fp before prog");
    step(); fp_req = 0;
    step(); expect_take(4, "R9 prog next");
    prog_req = 0; ext_req = 0; step(); step();

    // R4: checkstop on ME=0, sticky, blocks even sreset
    wr_msr(32'h0);
    mc_src = 5'b00010; step(); expect_take(0, "R4 no trap ME=0");
    chk(checkstop == 1, "R4 checkstop entry", checkstop, 1);
    mc_src = '0; sreset_req = 1;
    step(); step(); expect_take(0, "R4 no takes in checkstop");
    chk(checkstop == 1, "R4 checkstop sticky", checkstop, 1);
    sreset_req = 0;

    // constrained random episodes
    for (int ep = 0; ep < 20; ep++) begin
      do_reset();
      mc_en = MCS'($urandom);
      for (int cyc = 0; cyc < 300; cyc++) begin
        sreset_req  = ($urandom % 16) == 0;
        for (int s = 0; s < MCS; s++) mc_src[s] = ($urandom % 40) == 0;
        fp_req      = ($urandom % 4) == 0;
        prog_req    = ($urandom % 4) == 0;
        prog_info   = 10'($urandom);
        ext_req     = ($urandom % 3) == 0;
        dec_evt     = ($urandom % 8) == 0;
        older_clear = ($urandom % 4) != 0;
        fault_pc    = PW'($urandom);
        next_pc     = PW'($urandom);
        msr_wr_en   = ($urandom % 6) == 0;
        msr_wr_val  = $urandom;
        msr_wr_val[12] = ($urandom % 16) != 0;
        step();
      end
      idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule